// File: doc/BRIEF.md
# DMA Completion Interrupt Moderator

This block sits next to the descriptor rings of a DMA engine and turns single completion events into a moderated interrupt. It serves two rings: ring 0 for receive and ring 1 for transmit. For each ring it keeps a free-running 16-bit producer index. The index moves forward by one for every completed descriptor. Software writes a 16-bit consumer index back. The difference between the two, taken modulo 65536, is the number of descriptors still waiting for software.

A ring reports "done" in one of two cases, whichever happens first. The first case is when the pending count reaches a programmed completion threshold. The second is when a programmed number of timer ticks passes while descriptors are still pending. Each tick is `TICK_CYC` clock cycles, which is 1024 by default: at a 125 MHz clock, 57 µs is about 7 ticks. Done events land in a status register. Software clears status bits by writing ones to them. A set-mask operation and a clear-mask operation disable or enable each source, and the interrupt line is the OR of the status bits that are not masked.

Top module: `dma_irq_moderator`

## Requirements
- R1: Each cycle with `cmpl_evt[r]` high advances `prod_idx[r]` by one, and the index wraps from 65535 to 0.
- R2: `pending[r]` equals (`prod_idx[r]` − consumer index) mod 65536, where the consumer index is loaded from `cons_idx[r]` when `cons_wr[r]` is high.
- R3: Status bit r sets on the clock edge where the pending count first rises to at least `cnt_thr[r]`. A threshold of 0 acts as 1. Further completions while the count is already at or above the threshold do not set the bit again.
- R4: A consumer write whose new pending count is at or above the threshold sets status bit r on that edge. A write that leaves the count below the threshold does not set it.
- R5: The ring timer starts when a completion arrives while nothing is pending. The timer sets status bit r exactly `tmo_ticks[r]`×`TICK_CYC` clock edges after that start, provided the count threshold has not fired first.
- R6: A consumer write that leaves descriptors pending restarts the timer from zero.
- R7: A `tmo_ticks[r]` of 0 disables the timer path. The timer also stops when the pending count drops to 0.
- R8: Writing with `reg_op` = 0 clears every status bit whose `reg_data` bit is 1. If a done event for that bit arrives on the same edge, the bit stays set.
- R9: `reg_op` = 1 sets the mask bits given by `reg_data`, and `reg_op` = 2 clears them. `reg_op` = 3 does nothing. `irq` is high when any status bit is set and its mask bit is clear.
- R10: Bit 0 of status, mask and `reg_data` is the receive ring (ring 0), and bit 1 is the transmit ring (ring 1). After reset, status is 0, the mask is all ones, and both indices are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_evt | input | NSRC | One descriptor completed on ring r |
| cons_wr | input | NSRC | Load the consumer index of ring r |
| cons_idx | input | NSRC×16 | New consumer index for each ring |
| cnt_thr | input | NSRC×THR_W | Completion-count threshold for each ring |
| tmo_ticks | input | NSRC×TMO_W | Timeout in ticks for each ring; 0 turns the timer off |
| reg_wr | input | 1 | Perform the status or mask operation |
| reg_op | input | 2 | 0 clear status, 1 set mask, 2 clear mask, 3 none |
| reg_data | input | NSRC | Bit selection for the operation |
| irq | output | 1 | Moderated interrupt |
| irq_status | output | NSRC | Status bits |
| irq_mask | output | NSRC | Mask bits |
| prod_idx | output | NSRC×16 | Producer index of each ring |
| pending | output | NSRC×16 | Pending descriptor count of each ring |

## Verification
The critical coincidence is a done event and a write-one-to-clear of the same status bit on the same edge. The bench creates it by driving the transmit ring's completion that reaches its threshold together with a clear of bit 1. It then expects bit 1 to stay set, and expects a later plain clear to remove it. A second overlap is a consumer write that both restarts the timer and pushes the pending count over the threshold. Here the count path wins and the timer is not left running. The bench checks this by reading status across the following timeout window.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
    localparam int unsigned RING_IDX_W = 16;

    typedef enum logic [1:0] {
        OP_W1C  = 2'd0,
        OP_MSET = 2'd1,
        OP_MCLR = 2'd2,
        OP_NONE = 2'd3
    } reg_op_e;
endpackage

// File: rtl/irqm_ring.sv
module irqm_ring #(
    parameter int unsigned IDX_W    = 16,
    parameter int unsigned THR_W    = 8,
    parameter int unsigned TMO_W    = 8,
    parameter int unsigned TICK_CYC = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             cons_wr_i,
    input  logic [IDX_W-1:0] cons_i,
    input  logic [THR_W-1:0] thr_i,
    input  logic [TMO_W-1:0] tmo_i,
    output logic             fire_o,
    output logic [IDX_W-1:0] prod_o,
    output logic [IDX_W-1:0] pend_o
);
    localparam int unsigned PRE_W = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;

    typedef struct packed {
        logic [IDX_W-1:0] prod;
        logic [IDX_W-1:0] cons;
        logic             hit;
        logic             run;
        logic [PRE_W-1:0] pre;
        logic [TMO_W-1:0] tmr;
    } ring_s;

    ring_s s_d, s_q;
    logic [IDX_W-1:0] pend_q, pend_d;
    logic [THR_W-1:0] thr_eff;
    logic             cnt_fire, tmr_fire, start;

    always_comb begin
        s_d      = s_q;
        tmr_fire = 1'b0;
        if (evt_i)     s_d.prod = s_q.prod + 1'b1;
        if (cons_wr_i) s_d.cons = cons_i;
        pend_q   = s_q.prod - s_q.cons;
        pend_d   = s_d.prod - s_d.cons;
        thr_eff  = (thr_i == '0) ? THR_W'(1) : thr_i;
        s_d.hit  = (pend_d >= IDX_W'(thr_eff));
        cnt_fire = s_d.hit && (!s_q.hit || cons_wr_i);
        start    = cons_wr_i || (evt_i && (pend_q == '0));
        if (start) begin
            s_d.run = (pend_d != '0);
            s_d.pre = '0;
            s_d.tmr = '0;
        end else if (s_q.run) begin
            if (pend_d == '0) begin
                s_d.run = 1'b0;
            end else if (s_q.pre == PRE_W'(TICK_CYC - 1)) begin
                s_d.pre = '0;
                s_d.tmr = s_q.tmr + 1'b1;
                if ((tmo_i != '0) && (TMO_W'(s_q.tmr + 1'b1) == tmo_i)) begin
                    tmr_fire = 1'b1;
                    s_d.run  = 1'b0;
                end
            end else begin
                s_d.pre = s_q.pre + 1'b1;
            end
        end
        if (cnt_fire) s_d.run = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fire_o = cnt_fire | tmr_fire;
    assign prod_o = s_q.prod;
    assign pend_o = pend_q;

    // R1: producer moves by exactly one per completion
    a_r1_prod_step: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> (prod_o == IDX_W'($past(prod_o) + 1'b1)));

    // R3: the completion that brings the count to the threshold raises an event
    a_r3_reach_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && !cons_wr_i && (pend_o == IDX_W'(thr_eff) - 1'b1)) |-> fire_o);

    // R7: an empty ring with no activity stays quiet
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_o == '0) && !evt_i && !cons_wr_i) |-> !fire_o);
endmodule

// File: rtl/irqm_status.sv
module irqm_status #(
    parameter int unsigned NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] fire_i,
    input  logic            wr_i,
    input  logic [1:0]      op_i,
    input  logic [NSRC-1:0] data_i,
    output logic [NSRC-1:0] status_o,
    output logic [NSRC-1:0] mask_o,
    output logic            irq_o
);
    import irqm_pkg::*;

    typedef struct packed {
        logic [NSRC-1:0] status;
        logic [NSRC-1:0] mask;
    } st_s;

    st_s             s_d, s_q;
    reg_op_e         op;
    logic [NSRC-1:0] clr;

    always_comb begin
        s_d = s_q;
        op  = reg_op_e'(op_i);
        clr = '0;
        if (wr_i) begin
            case (op)
                OP_W1C:  clr = data_i;
                OP_MSET: s_d.mask = s_q.mask | data_i;
                OP_MCLR: s_d.mask = s_q.mask & ~data_i;
                default: ;
            endcase
        end
        s_d.status = (s_q.status & ~clr) | fire_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.status <= '0;
            s_q.mask   <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign status_o = s_q.status;
    assign mask_o   = s_q.mask;
    assign irq_o    = |(s_q.status & ~s_q.mask);

    for (genvar b = 0; b < NSRC; b++) begin : g_chk
        // R8: a coincident event beats the clear
        a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && (op_i == 2'd0) && data_i[b] && fire_i[b]) |=> status_o[b]);
        // R8: a clear with no event empties the bit
        a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && (op_i == 2'd0) && data_i[b] && !fire_i[b]) |=> !status_o[b]);
        // R9: mask set and clear operations
        a_r9_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && (op_i == 2'd1) && data_i[b]) |=> mask_o[b]);
        a_r9_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && (op_i == 2'd2) && data_i[b]) |=> !mask_o[b]);
    end
endmodule

// File: rtl/dma_irq_moderator.sv
module dma_irq_moderator #(
    parameter int unsigned NSRC     = 2,
    parameter int unsigned THR_W    = 8,
    parameter int unsigned TMO_W    = 8,
    parameter int unsigned TICK_CYC = 1024
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NSRC-1:0]                       cmpl_evt,
    input  logic [NSRC-1:0]                       cons_wr,
    input  logic [NSRC-1:0][irqm_pkg::RING_IDX_W-1:0] cons_idx,
    input  logic [NSRC-1:0][THR_W-1:0]            cnt_thr,
    input  logic [NSRC-1:0][TMO_W-1:0]            tmo_ticks,
    input  logic                                  reg_wr,
    input  logic [1:0]                            reg_op,
    input  logic [NSRC-1:0]                       reg_data,
    output logic                                  irq,
    output logic [NSRC-1:0]                       irq_status,
    output logic [NSRC-1:0]                       irq_mask,
    output logic [NSRC-1:0][irqm_pkg::RING_IDX_W-1:0] prod_idx,
    output logic [NSRC-1:0][irqm_pkg::RING_IDX_W-1:0] pending
);
    localparam int unsigned IDX_W = irqm_pkg::RING_IDX_W;

    logic [NSRC-1:0] fire;

    for (genvar g = 0; g < NSRC; g++) begin : g_ring
        irqm_ring #(
            .IDX_W    (IDX_W),
            .THR_W    (THR_W),
            .TMO_W    (TMO_W),
            .TICK_CYC (TICK_CYC)
        ) u_ring (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (cmpl_evt[g]),
            .cons_wr_i (cons_wr[g]),
            .cons_i    (cons_idx[g]),
            .thr_i     (cnt_thr[g]),
            .tmo_i     (tmo_ticks[g]),
            .fire_o    (fire[g]),
            .prod_o    (prod_idx[g]),
            .pend_o    (pending[g])
        );
    end

    irqm_status #(.NSRC(NSRC)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (fire),
        .wr_i     (reg_wr),
        .op_i     (reg_op),
        .data_i   (reg_data),
        .status_o (irq_status),
        .mask_o   (irq_mask),
        .irq_o    (irq)
    );
endmodule

// File: tb/dma_irq_moderator_tb_top.sv
module dma_irq_moderator_tb_top;
    localparam int TICK = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       cmpl_evt = '0, cons_wr = '0, reg_data = '0;
    logic [1:0][15:0] cons_idx = '0;
    logic [1:0][7:0]  cnt_thr, tmo_ticks;
    logic             reg_wr = 1'b0;
    logic [1:0]       reg_op = 2'd3;
    logic             irq;
    logic [1:0]       irq_status, irq_mask;
    logic [1:0][15:0] prod_idx, pending;

    int total = 0, failed = 0;
    bit finished = 0;

    typedef struct {
        string       tag;
        logic [1:0]  st;
        logic [1:0]  mk;
        logic        irq;
        logic [15:0] p0;
        logic [15:0] p1;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    dma_irq_moderator #(.NSRC(2), .THR_W(8), .TMO_W(8), .TICK_CYC(TICK)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmpl_evt(cmpl_evt), .cons_wr(cons_wr),
        .cons_idx(cons_idx), .cnt_thr(cnt_thr), .tmo_ticks(tmo_ticks),
        .reg_wr(reg_wr), .reg_op(reg_op), .reg_data(reg_data), .irq(irq),
        .irq_status(irq_status), .irq_mask(irq_mask), .prod_idx(prod_idx),
        .pending(pending)
    );

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            exp_t e;
            wait (sb.size() != 0);
            e = sb.pop_front();
            total++;
            if (irq_status !== e.st || irq_mask !== e.mk || irq !== e.irq ||
                pending[0] !== e.p0 || pending[1] !== e.p1) begin
                failed++;
                $display("FAIL %s: got st=%b mk=%b irq=%b p0=%0d p1=%0d exp st=%b mk=%b irq=%b p0=%0d p1=%0d",
                         e.tag, irq_status, irq_mask, irq, pending[0], pending[1],
                         e.st, e.mk, e.irq, e.p0, e.p1);
            end
        end
    end

    task automatic expect_state(string tag, logic [1:0] st, logic [1:0] mk,
                                logic i, logic [15:0] p0, logic [15:0] p1);
        exp_t e;
        e.tag = tag; e.st = st; e.mk = mk; e.irq = i; e.p0 = p0; e.p1 = p1;
        sb.push_back(e);
        #1;
    endtask

    task automatic drive(logic [1:0] ev, logic [1:0] cw, logic [15:0] c0, logic [15:0] c1,
                         logic rw, logic [1:0] op, logic [1:0] d);
        @(negedge clk);
        cmpl_evt = ev; cons_wr = cw; cons_idx[0] = c0; cons_idx[1] = c1;
        reg_wr = rw; reg_op = op; reg_data = d;
        @(negedge clk);
        cmpl_evt = '0; cons_wr = '0; reg_wr = 1'b0; reg_op = 2'd3;
    endtask

    task automatic ev(logic [1:0] r);
        drive(r, 2'b00, cons_idx[0], cons_idx[1], 1'b0, 2'd3, 2'b00);
    endtask

    task automatic op(logic [1:0] o, logic [1:0] d);
        drive(2'b00, 2'b00, cons_idx[0], cons_idx[1], 1'b1, o, d);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; failed++;
            $display("FAIL watchdog: got running exp finished");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        cnt_thr[0] = 8'd3; cnt_thr[1] = 8'd4;
        tmo_ticks[0] = 8'd0; tmo_ticks[1] = 8'd2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_state("R10 reset state", 2'b00, 2'b11, 0, 0, 0);

        op(2'd2, 2'b11);
        expect_state("R9 clear-mask enables both", 2'b00, 2'b00, 0, 0, 0);

        ev(2'b01); ev(2'b01);
        expect_state("R2 pending below threshold", 2'b00, 2'b00, 0, 2, 0);
        ev(2'b01);
        expect_state("R3 threshold reached rx", 2'b01, 2'b00, 1, 3, 0);
        op(2'd0, 2'b01);
        expect_state("R8 w1c clears rx", 2'b00, 2'b00, 0, 3, 0);

        drive(2'b00, 2'b01, 16'd1, 16'd0, 1'b0, 2'd3, 2'b00);
        expect_state("R4 consumer write below threshold", 2'b00, 2'b00, 0, 2, 0);
        ev(2'b01);
        expect_state("R3 reach again after consume", 2'b01, 2'b00, 1, 3, 0);
        op(2'd0, 2'b01);
        ev(2'b01);
        expect_state("R3 no refire above threshold", 2'b00, 2'b00, 0, 4, 0);
        drive(2'b00, 2'b01, 16'd2, 16'd0, 1'b0, 2'd3, 2'b00);
        expect_state("R4 consumer write still at threshold", 2'b01, 2'b00, 1, 3, 0);
        op(2'd0, 2'b01);

        drive(2'b00, 2'b01, 16'd5, 16'd0, 1'b0, 2'd3, 2'b00);
        ev(2'b01);
        idle(100);
        expect_state("R7 zero timeout never fires", 2'b00, 2'b00, 0, 1, 0);
        drive(2'b00, 2'b01, 16'd6, 16'd0, 1'b0, 2'd3, 2'b00);

        ev(2'b10);
        idle(2 * TICK - 1);
        expect_state("R5 one cycle before timeout", 2'b00, 2'b00, 0, 0, 1);
        idle(1);
        expect_state("R5 timeout expiry tx", 2'b10, 2'b00, 1, 0, 1);

        op(2'd1, 2'b10);
        expect_state("R9 set-mask hides tx", 2'b10, 2'b10, 0, 0, 1);
        op(2'd3, 2'b11);
        expect_state("R9 op 3 has no effect", 2'b10, 2'b10, 0, 0, 1);
        op(2'd0, 2'b10);
        ev(2'b10); ev(2'b10);
        drive(2'b10, 2'b00, 16'd6, 16'd0, 1'b1, 2'd0, 2'b10);
        expect_state("R8 event beats coincident w1c", 2'b10, 2'b10, 0, 0, 4);
        op(2'd0, 2'b10);
        expect_state("R8 plain w1c clears tx", 2'b00, 2'b10, 0, 0, 4);

        drive(2'b00, 2'b10, 16'd6, 16'hFFFE, 1'b0, 2'd3, 2'b00);
        expect_state("R2 modulo pending across wrap", 2'b10, 2'b10, 0, 0, 6);
        op(2'd0, 2'b10);
        idle(2 * TICK + 4);
        expect_state("R4 count fire leaves timer stopped", 2'b00, 2'b10, 0, 0, 6);

        drive(2'b00, 2'b10, 16'd6, 16'd2, 1'b0, 2'd3, 2'b00);
        idle(2 * TICK - 1);
        expect_state("R6 restart before expiry", 2'b00, 2'b10, 0, 0, 2);
        idle(1);
        expect_state("R6 restarted timer expires", 2'b10, 2'b10, 0, 0, 2);
        op(2'd2, 2'b10);
        expect_state("R9 unmask raises irq", 2'b10, 2'b00, 1, 0, 2);
        op(2'd0, 2'b10);

        drive(2'b00, 2'b10, 16'd6, 16'd4, 1'b0, 2'd3, 2'b00);
        idle(3 * TICK);
        expect_state("R7 empty ring stops timer", 2'b00, 2'b00, 0, 0, 0);

        @(negedge clk);
        cmpl_evt = 2'b01;
        repeat (65536) @(negedge clk);
        cmpl_evt = 2'b00;
        expect_state("R1 producer wraps after 65536 events", 2'b01, 2'b00, 1, 0, 0);

        idle(2);
        finished = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule